// File: doc/BRIEF.md
# Serial Frame Transmit Data Sequencer

This block feeds the data field of one outgoing frame on a multi-master serial bus. The receive side reports a control code. The block then raises an interrupt, so the host can program a byte count and place the first byte in a one-byte write buffer. The bit-level transmitter signals the end of the length field. From then on the block offers bytes one at a time over a request/done handshake until the count is used up.

Some control codes ask for slave status or the lock address. For these the block makes up the bytes itself and leaves the write buffer untouched. A frame can end early for three reasons: the buffer is empty when the first data byte is due, a parity or transmit error is reported, or the per-frame cap is reached. In each of these cases the block loads an abort state code and raises the interrupt. The state code, the interrupt and the error flags stay set until the host clears them.

Top module: `tx_frame_sequencer`

## Requirements
- R1: After reset, state_code is 0H, irq, all error flags, buf_ovr, busy and tx_req are 0, buf_empty is 1, and the byte count is 0.
- R2: A ctrl_rx pulse while idle latches ctrl_code, loads state code 1H, sets irq and makes busy 1. A ctrl_rx pulse while busy is ignored.
- R3: A byte count of 0 means 256 bytes.
- R4: tx_req is high only in the data phase, and in host mode only while the write buffer is full. tx_byte then carries the buffered byte. Each byte accepted with tx_done empties the buffer.
- R5: When the accepted byte count reaches the programmed total, state code 2H is loaded, irq is set and the block goes idle.
- R6: In host mode, if the buffer is empty at the len_sent pulse, err_timing is set, state code 3H is loaded, irq is set and no byte is requested.
- R7: Control codes 0H, 4H, 5H and 6H select self-generated bytes. 0H and 6H send slave_stat, 4H sends lock_addr[7:0] and 5H sends lock_addr[11:8] zero-extended. The write buffer is neither required nor consumed in this mode.
- R8: If FRAME_MAX bytes have gone out before the total is reached, state code 3H is loaded, irq is set and no error flag is set.
- R9: tx_par_err or tx_bit_err during the length-wait or data phase sets err_parity or err_tx respectively, loads state code 3H, sets irq and ends the frame.
- R10: A buffer write while the buffer is full is ignored and sets buf_ovr.
- R11: A host_clr pulse clears state_code, irq, the error flags and buf_ovr. An event that sets any of these in the same cycle wins.
- R12: A byte count write during the data phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_rx | input | 1 | Control code received pulse |
| ctrl_code | input | 4 | Received control code |
| cnt_we | input | 1 | Byte count write strobe |
| cnt_wdata | input | 8 | Byte count (0 = 256) |
| buf_we | input | 1 | Write buffer write strobe |
| buf_wdata | input | 8 | Write buffer data |
| host_clr | input | 1 | Write-one-to-clear of status |
| slave_stat | input | 8 | Slave status byte |
| lock_addr | input | 12 | Lock address |
| len_sent | input | 1 | Length field finished pulse |
| tx_done | input | 1 | Offered byte accepted |
| tx_par_err | input | 1 | Parity error pulse |
| tx_bit_err | input | 1 | Transmit error pulse |
| tx_req | output | 1 | Byte available |
| tx_byte | output | 8 | Byte offered to transmitter |
| buf_empty | output | 1 | Write buffer empty |
| buf_ovr | output | 1 | Write buffer overrun |
| state_code | output | 4 | Frame state code |
| irq | output | 1 | Transmit interrupt |
| err_timing | output | 1 | Empty-buffer timing error |
| err_parity | output | 1 | Parity error |
| err_tx | output | 1 | Transmit error |
| busy | output | 1 | Frame in progress |

## Verification
Some properties are checked by assertions on every cycle. The sent counter never passes FRAME_MAX. No byte is requested while idle. A full buffer keeps its contents when a second write arrives. A finishing byte always leaves state 2H with irq. A clear with no competing event empties the status. A self-generated frame never empties the buffer. Other behaviour needs the bench's scenarios, checked against its reference model: byte order, the meaning of a zero count, the choice of auto byte for each code, the empty-buffer abort and the handling of a count written mid-frame.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_WAIT_LEN = 2'd1,
        PH_SEND     = 2'd2
    } phase_t;

    localparam logic [3:0] ST_NONE  = 4'h0;
    localparam logic [3:0] ST_CTRL  = 4'h1;
    localparam logic [3:0] ST_DONE  = 4'h2;
    localparam logic [3:0] ST_ABORT = 4'h3;

    function automatic logic is_auto_code(input logic [3:0] c);
        return (c == 4'h0) || (c == 4'h4) || (c == 4'h5) || (c == 4'h6);
    endfunction
endpackage

// File: rtl/tx_wbuf.sv
module tx_wbuf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              take,
    input  logic              clr_ovr,
    output logic              full,
    output logic [BYTE_W-1:0] data,
    output logic              ovr
);
    typedef struct packed {
        logic              full;
        logic [BYTE_W-1:0] data;
        logic              ovr;
    } wb_t;

    wb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_ovr) s_d.ovr = 1'b0;
        if (wr_en) begin
            if (s_q.full) begin
                s_d.ovr = 1'b1;
            end else begin
                s_d.full = 1'b1;
                s_d.data = wr_data;
            end
        end
        if (take) s_d.full = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign full = s_q.full;
    assign data = s_q.data;
    assign ovr  = s_q.ovr;

    p_ovr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && wr_en && !take) |=> ($stable(s_q.data) && s_q.ovr));
endmodule

// File: rtl/tx_auto_src.sv
module tx_auto_src #(
    parameter int BYTE_W = 8,
    parameter int LOCK_W = 12
) (
    input  logic [3:0]        code,
    input  logic [BYTE_W-1:0] slave_stat,
    input  logic [LOCK_W-1:0] lock_addr,
    output logic [BYTE_W-1:0] auto_byte
);
    localparam int HI_W = LOCK_W - BYTE_W;

    logic [BYTE_W-1:0] lock_lo, lock_hi;

    assign lock_lo = lock_addr[BYTE_W-1:0];

    generate
        if (HI_W > 0) begin : g_hi
            assign lock_hi = BYTE_W'(lock_addr[LOCK_W-1:BYTE_W]);
        end else begin : g_nohi
            assign lock_hi = '0;
        end
    endgenerate

    always_comb begin
        unique case (code)
            4'h4:    auto_byte = lock_lo;
            4'h5:    auto_byte = lock_hi;
            default: auto_byte = slave_stat;
        endcase
    end
endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
    import tx_seq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int FRAME_MAX = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_rx,
    input  logic [3:0]       ctrl_code,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             host_clr,
    input  logic             len_sent,
    input  logic             tx_done,
    input  logic             tx_par_err,
    input  logic             tx_bit_err,
    input  logic             buf_full,
    output logic             tx_req,
    output logic             auto_mode,
    output logic [3:0]       act_code,
    output logic             busy,
    output logic [3:0]       state_code,
    output logic             irq,
    output logic             err_timing,
    output logic             err_parity,
    output logic             err_tx
);
    localparam int TOT_W  = CNT_W + 1;
    localparam int CAP_W  = $clog2(FRAME_MAX + 1);
    localparam int SENT_W = (CAP_W > TOT_W) ? CAP_W : TOT_W;

    typedef struct packed {
        phase_t            phase;
        logic              auto_m;
        logic [3:0]        code;
        logic [CNT_W-1:0]  cnt;
        logic [SENT_W-1:0] sent;
        logic [3:0]        sc;
        logic              irq;
        logic              et;
        logic              ep;
        logic              ex;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [SENT_W-1:0] total;
    logic [SENT_W-1:0] sent_inc;
    logic              any_err;
    logic              accept;

    assign total    = (s_q.cnt == '0) ? SENT_W'(1 << CNT_W) : SENT_W'(s_q.cnt);
    assign sent_inc = s_q.sent + 1'b1;
    assign any_err  = tx_par_err || tx_bit_err;
    assign tx_req   = (s_q.phase == PH_SEND) && (s_q.auto_m || buf_full);
    assign accept   = tx_req && tx_done;

    always_comb begin
        s_d = s_q;
        if (host_clr) begin
            s_d.sc  = ST_NONE;
            s_d.irq = 1'b0;
            s_d.et  = 1'b0;
            s_d.ep  = 1'b0;
            s_d.ex  = 1'b0;
        end
        if (cnt_we && s_q.phase != PH_SEND) s_d.cnt = cnt_wdata;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (ctrl_rx) begin
                    s_d.code   = ctrl_code;
                    s_d.auto_m = is_auto_code(ctrl_code);
                    s_d.sc     = ST_CTRL;
                    s_d.irq    = 1'b1;
                    s_d.phase  = PH_WAIT_LEN;
                end
            end
            PH_WAIT_LEN: begin
                if (any_err) begin
                    s_d.ep    = s_q.ep | tx_par_err;
                    s_d.ex    = s_q.ex | tx_bit_err;
                    s_d.sc    = ST_ABORT;
                    s_d.irq   = 1'b1;
                    s_d.phase = PH_IDLE;
                end else if (len_sent) begin
                    if (!s_q.auto_m && !buf_full) begin
                        s_d.et    = 1'b1;
                        s_d.sc    = ST_ABORT;
                        s_d.irq   = 1'b1;
                        s_d.phase = PH_IDLE;
                    end else begin
                        s_d.sent  = '0;
                        s_d.phase = PH_SEND;
                    end
                end
            end
            PH_SEND: begin
                if (any_err) begin
                    s_d.ep    = s_q.ep | tx_par_err;
                    s_d.ex    = s_q.ex | tx_bit_err;
                    s_d.sc    = ST_ABORT;
                    s_d.irq   = 1'b1;
                    s_d.phase = PH_IDLE;
                end else if (accept) begin
                    s_d.sent = sent_inc;
                    if (sent_inc == total) begin
                        s_d.sc    = ST_DONE;
                        s_d.irq   = 1'b1;
                        s_d.phase = PH_IDLE;
                    end else if (sent_inc == SENT_W'(FRAME_MAX)) begin
                        s_d.sc    = ST_ABORT;
                        s_d.irq   = 1'b1;
                        s_d.phase = PH_IDLE;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign auto_mode  = s_q.auto_m;
    assign act_code   = s_q.code;
    assign busy       = (s_q.phase != PH_IDLE);
    assign state_code = s_q.sc;
    assign irq        = s_q.irq;
    assign err_timing = s_q.et;
    assign err_parity = s_q.ep;
    assign err_tx     = s_q.ex;

    p_sent_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sent <= SENT_W'(FRAME_MAX));

    p_idle_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_IDLE) |-> !tx_req);

    p_done_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_SEND && tx_req && tx_done && !any_err && sent_inc == total)
        |=> (s_q.sc == ST_DONE && s_q.irq && s_q.phase == PH_IDLE));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr && s_q.phase == PH_IDLE && !ctrl_rx)
        |=> (!s_q.irq && s_q.sc == ST_NONE && !s_q.et && !s_q.ep && !s_q.ex));
endmodule

// File: rtl/tx_frame_sequencer.sv
module tx_frame_sequencer #(
    parameter int BYTE_W    = 8,
    parameter int LOCK_W    = 12,
    parameter int FRAME_MAX = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_rx,
    input  logic [3:0]        ctrl_code,
    input  logic              cnt_we,
    input  logic [BYTE_W-1:0] cnt_wdata,
    input  logic              buf_we,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              host_clr,
    input  logic [BYTE_W-1:0] slave_stat,
    input  logic [LOCK_W-1:0] lock_addr,
    input  logic              len_sent,
    input  logic              tx_done,
    input  logic              tx_par_err,
    input  logic              tx_bit_err,
    output logic              tx_req,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              buf_empty,
    output logic              buf_ovr,
    output logic [3:0]        state_code,
    output logic              irq,
    output logic              err_timing,
    output logic              err_parity,
    output logic              err_tx,
    output logic              busy
);
    logic              buf_full;
    logic [BYTE_W-1:0] buf_data;
    logic [BYTE_W-1:0] auto_byte;
    logic              auto_mode;
    logic [3:0]        act_code;
    logic              take;

    assign take = tx_req && tx_done && !auto_mode && !tx_par_err && !tx_bit_err;

    tx_wbuf #(.BYTE_W(BYTE_W)) u_wbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_we),
        .wr_data (buf_wdata),
        .take    (take),
        .clr_ovr (host_clr),
        .full    (buf_full),
        .data    (buf_data),
        .ovr     (buf_ovr)
    );

    tx_auto_src #(.BYTE_W(BYTE_W), .LOCK_W(LOCK_W)) u_auto (
        .code       (act_code),
        .slave_stat (slave_stat),
        .lock_addr  (lock_addr),
        .auto_byte  (auto_byte)
    );

    tx_seq_fsm #(.CNT_W(BYTE_W), .FRAME_MAX(FRAME_MAX)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_rx    (ctrl_rx),
        .ctrl_code  (ctrl_code),
        .cnt_we     (cnt_we),
        .cnt_wdata  (cnt_wdata),
        .host_clr   (host_clr),
        .len_sent   (len_sent),
        .tx_done    (tx_done),
        .tx_par_err (tx_par_err),
        .tx_bit_err (tx_bit_err),
        .buf_full   (buf_full),
        .tx_req     (tx_req),
        .auto_mode  (auto_mode),
        .act_code   (act_code),
        .busy       (busy),
        .state_code (state_code),
        .irq        (irq),
        .err_timing (err_timing),
        .err_parity (err_parity),
        .err_tx     (err_tx)
    );

    assign tx_byte   = auto_mode ? auto_byte : buf_data;
    assign buf_empty = !buf_full;

    p_auto_keeps_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && auto_mode && !buf_full) |=> !buf_full || $past(buf_we));
    p_auto_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && auto_mode && buf_full) |=> buf_full);
endmodule

// File: tb/test_tx_frame_sequencer.sv
module test_tx_frame_sequencer;
    localparam int FMAX = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctrl_rx = 0, cnt_we = 0, buf_we = 0, host_clr = 0;
    logic len_sent = 0, tx_done = 0, tx_par_err = 0, tx_bit_err = 0;
    logic [3:0] ctrl_code = 0;
    logic [7:0] cnt_wdata = 0, buf_wdata = 0;
    logic [7:0] slave_stat = 8'hC5;
    logic [11:0] lock_addr = 12'hA3B;
    logic tx_req, buf_empty, buf_ovr, irq, err_timing, err_parity, err_tx, busy;
    logic [7:0] tx_byte;
    logic [3:0] state_code;

    int n_tests = 0, n_fail = 0, cyc = 0;

    tx_frame_sequencer #(.FRAME_MAX(FMAX)) i_tx_frame_sequencer (
        .clk(clk), .rst_n(rst_n), .ctrl_rx(ctrl_rx), .ctrl_code(ctrl_code),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .host_clr(host_clr), .slave_stat(slave_stat), .lock_addr(lock_addr),
        .len_sent(len_sent), .tx_done(tx_done), .tx_par_err(tx_par_err),
        .tx_bit_err(tx_bit_err), .tx_req(tx_req), .tx_byte(tx_byte),
        .buf_empty(buf_empty), .buf_ovr(buf_ovr), .state_code(state_code), .irq(irq),
        .err_timing(err_timing), .err_parity(err_parity), .err_tx(err_tx), .busy(busy));

    always #10 clk = ~clk;

    // behavioural reference model
    int m_ph = 0, m_code = 0, m_cnt = 0, m_sent = 0, m_sc = 0, m_data = 0;
    bit m_auto = 0, m_full = 0, m_ovr = 0, m_irq = 0, m_et = 0, m_ep = 0, m_ex = 0;

    function automatic bit m_req();
        return (m_ph == 2) && (m_auto || m_full);
    endfunction
    function automatic int m_byte();
        if (!m_auto) return m_data;
        if (m_code == 4) return int'(lock_addr[7:0]);
        if (m_code == 5) return int'(lock_addr[11:8]);
        return int'(slave_stat);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_code = 0; m_cnt = 0; m_sent = 0; m_sc = 0; m_data = 0;
            m_auto = 0; m_full = 0; m_ovr = 0; m_irq = 0; m_et = 0; m_ep = 0; m_ex = 0;
        end else begin
            automatic bit req = m_req();
            automatic bit err = tx_par_err || tx_bit_err;
            automatic int tot = (m_cnt == 0) ? 256 : m_cnt;
            automatic int ph = m_ph;
            automatic bit was_full = m_full;
            if (host_clr) begin m_sc = 0; m_irq = 0; m_et = 0; m_ep = 0; m_ex = 0; m_ovr = 0; end
            if (buf_we) begin
                if (was_full) m_ovr = 1;
                else begin m_full = 1; m_data = int'(buf_wdata); end
            end
            if (cnt_we && ph != 2) m_cnt = int'(cnt_wdata);
            if (ph == 0) begin
                if (ctrl_rx) begin
                    m_code = int'(ctrl_code);
                    m_auto = (ctrl_code == 0) || (ctrl_code == 4) || (ctrl_code == 5) || (ctrl_code == 6);
                    m_sc = 1; m_irq = 1; m_ph = 1;
                end
            end else if (err) begin
                if (tx_par_err) m_ep = 1;
                if (tx_bit_err) m_ex = 1;
                m_sc = 3; m_irq = 1; m_ph = 0;
            end else if (ph == 1) begin
                if (len_sent) begin
                    if (!m_auto && !was_full) begin m_et = 1; m_sc = 3; m_irq = 1; m_ph = 0; end
                    else begin m_sent = 0; m_ph = 2; end
                end
            end else if (req && tx_done) begin
                if (!m_auto) m_full = 0;
                m_sent++;
                if (m_sent == tot) begin m_sc = 2; m_irq = 1; m_ph = 0; end
                else if (m_sent == FMAX) begin m_sc = 3; m_irq = 1; m_ph = 0; end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // per-cycle comparison with the model, plus watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000", cyc);
            finish_up();
        end
        chk(tx_req == m_req(), "R4 tx_req", tx_req, m_req());
        if (tx_req && m_req()) chk(int'(tx_byte) == m_byte(), "R7 tx_byte", tx_byte, m_byte());
        chk(int'(state_code) == m_sc, "R2 state_code", state_code, m_sc);
        chk(irq == m_irq, "R11 irq", irq, m_irq);
        chk(err_timing == m_et, "R6 err_timing", err_timing, m_et);
        chk(err_parity == m_ep && err_tx == m_ex, "R9 err flags",
            {err_parity, err_tx}, {m_ep, m_ex});
        chk(buf_empty == !m_full, "R10 buf_empty", buf_empty, !m_full);
        chk(buf_ovr == m_ovr, "R10 buf_ovr", buf_ovr, m_ovr);
        chk(busy == (m_ph != 0), "R2 busy", busy, m_ph != 0);
    end

    task automatic p_ctrl(input logic [3:0] c);
        @(posedge clk); #1 ctrl_rx = 1; ctrl_code = c;
        @(posedge clk); #1 ctrl_rx = 0;
    endtask
    task automatic p_cnt(input logic [7:0] v);
        @(posedge clk); #1 cnt_we = 1; cnt_wdata = v;
        @(posedge clk); #1 cnt_we = 0;
    endtask
    task automatic p_buf(input logic [7:0] v);
        @(posedge clk); #1 buf_we = 1; buf_wdata = v;
        @(posedge clk); #1 buf_we = 0;
    endtask
    task automatic p_clr();
        @(posedge clk); #1 host_clr = 1;
        @(posedge clk); #1 host_clr = 0;
    endtask
    task automatic p_len();
        @(posedge clk); #1 len_sent = 1;
        @(posedge clk); #1 len_sent = 0;
    endtask
    task automatic p_done();
        @(posedge clk); #1 tx_done = 1;
        @(posedge clk); #1 tx_done = 0;
    endtask
    task automatic p_perr();
        @(posedge clk); #1 tx_par_err = 1;
        @(posedge clk); #1 tx_par_err = 0;
    endtask
    task automatic wait_req();
        for (int k = 0; k < 50 && !tx_req; k++) @(negedge clk);
    endtask
    // host-mode byte: write, wait for request, check byte, accept
    task automatic host_byte(input logic [7:0] v, input string tag);
        p_buf(v);
        @(negedge clk);
        chk(tx_req && tx_byte == v, tag, tx_byte, v);
        p_done();
    endtask
    task automatic expect_end(input logic [3:0] sc, input string tag);
        @(negedge clk);
        chk(state_code == sc && irq && !busy, tag, state_code, sc);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(state_code == 0 && !irq && !busy && !tx_req && buf_empty && !buf_ovr,
            "R1 reset state", {state_code, irq, busy, tx_req}, 0);

        // R2 + R4 + R5: host frame of 3 bytes
        p_ctrl(4'h2);
        @(negedge clk);
        chk(state_code == 4'h1 && irq && busy, "R2 control received", state_code, 1);
        p_ctrl(4'h0);   // R2: ignored while busy
        @(negedge clk);
        chk(state_code == 4'h1 && !tx_req, "R2 ctrl while busy ignored", state_code, 1);
        p_clr(); p_cnt(8'd3); p_buf(8'hA1); p_len();
        @(negedge clk);
        chk(tx_req && tx_byte == 8'hA1, "R4 first byte", tx_byte, 8'hA1);
        p_done();
        @(negedge clk);
        chk(!tx_req && buf_empty, "R4 buffer emptied", tx_req, 0);
        host_byte(8'hA2, "R4 second byte");
        host_byte(8'hA3, "R4 third byte");
        expect_end(4'h2, "R5 frame complete");

        // R11 clear
        p_clr();
        @(negedge clk);
        chk(state_code == 0 && !irq, "R11 clear", state_code, 0);

        // R6 empty buffer at first data slot
        p_ctrl(4'h3); p_cnt(8'd2); p_len();
        expect_end(4'h3, "R6 empty buffer abort");
        chk(err_timing && !tx_req, "R6 timing flag", err_timing, 1);
        p_clr();

        // R7 auto codes, buffer pre-filled and left alone
        p_buf(8'h5E);
        p_ctrl(4'h5); p_cnt(8'd1); p_len();
        @(negedge clk);
        chk(tx_req && tx_byte == 8'h0A, "R7 lock high byte", tx_byte, 8'h0A);
        p_done();
        expect_end(4'h2, "R7 auto frame complete");
        chk(!buf_empty, "R7 buffer untouched", buf_empty, 0);
        p_clr();
        p_ctrl(4'h4); p_len();
        @(negedge clk);
        chk(tx_byte == 8'h3B, "R7 lock low byte", tx_byte, 8'h3B);
        p_done(); p_clr();
        p_ctrl(4'h0); p_len();
        @(negedge clk);
        chk(tx_byte == 8'hC5, "R7 slave status", tx_byte, 8'hC5);
        p_done(); p_clr();
        p_ctrl(4'h6); p_len();
        @(negedge clk);
        chk(tx_byte == 8'hC5, "R7 code 6 status", tx_byte, 8'hC5);
        p_done(); p_clr();

        // R10 overrun: buffer still holds 5E
        p_buf(8'h99);
        @(negedge clk);
        chk(buf_ovr, "R10 overrun flag", buf_ovr, 1);
        p_ctrl(4'h1); p_cnt(8'd1); p_len();
        @(negedge clk);
        chk(tx_byte == 8'h5E, "R10 write ignored", tx_byte, 8'h5E);
        p_done();
        expect_end(4'h2, "R10 frame after overrun");
        p_clr();

        // R3 + R8: count 0 means 256, capped at FMAX
        p_cnt(8'd0); p_ctrl(4'h1); p_buf(8'h00); p_len();
        @(negedge clk);
        p_done();
        for (int i = 1; i < FMAX; i++) host_byte(8'(i), "R3 long frame byte");
        expect_end(4'h3, "R3 zero count runs to cap");
        chk(!err_timing && !err_parity && !err_tx, "R8 cap has no error flag",
            {err_timing, err_parity, err_tx}, 0);
        p_clr();
        // count exactly FMAX completes
        p_cnt(8'(FMAX)); p_ctrl(4'h1);
        p_buf(8'h10); p_len(); @(negedge clk); p_done();
        for (int i = 1; i < FMAX; i++) host_byte(8'(i + 16), "R5 max frame byte");
        expect_end(4'h2, "R8 count equal to cap completes");
        p_clr();

        // R9 parity error mid frame
        p_ctrl(4'h2); p_cnt(8'd3); p_buf(8'h11); p_len();
        @(negedge clk); p_done();
        p_perr();
        expect_end(4'h3, "R9 parity abort");
        chk(err_parity && !err_tx, "R9 parity flag", err_parity, 1);
        p_clr();
        // R9 transmit error in length wait
        p_ctrl(4'h2);
        @(posedge clk); #1 tx_bit_err = 1;
        @(posedge clk); #1 tx_bit_err = 0;
        expect_end(4'h3, "R9 transmit error abort");
        chk(err_tx, "R9 transmit flag", err_tx, 1);
        // R11 set wins over clear
        @(posedge clk); #1 host_clr = 1; ctrl_rx = 1; ctrl_code = 4'h2;
        @(posedge clk); #1 host_clr = 0; ctrl_rx = 0;
        @(negedge clk);
        chk(irq && state_code == 4'h1 && !err_tx, "R11 set wins", state_code, 1);

        // R12 count write in data phase ignored
        p_cnt(8'd2); p_buf(8'h21); p_len();
        p_cnt(8'd1);
        @(negedge clk); p_done();
        @(negedge clk);
        chk(busy, "R12 count write ignored", busy, 1);
        host_byte(8'h22, "R12 second byte");
        expect_end(4'h2, "R12 frame of two");

        repeat (3) @(negedge clk);
        finish_up();
    end
endmodule